// File: doc/BRIEF.md
# Load Result Formatter

This block sits between a load unit's data return and the register file's write port. It takes the raw bytes that memory returned for one load, together with the access size and two mode flags, and produces the 64-bit value to be written into the destination register. The loaded bytes arrive right-justified in the data input. In big-endian terms the access's first byte is the most significant one present. Any input bits above the access size are don't-care.

Three formatting operations share one path. The plain form zero-fills the register above the access. The algebraic form, allowed only for halfword and word accesses, fills the upper bits with the access's most significant bit. The byte-swapped form reverses the byte order inside the access and always zero-fills above it. Mode combinations the format does not support produce a zero result and raise an error flag. Everything passes through one register stage, so a result and its destination register number appear one clock after the input is accepted.

Top module: `ldfmt_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, out_err, out_data and out_tag are all zero.
- R2: out_valid is high exactly one cycle after each cycle in which in_valid is high, and out_tag then carries the in_tag given with that input.
- R3: Size code 2'b00 (byte) with no flags gives out_data[7:0] = in_data[7:0] and zeros in out_data[63:8].
- R4: Size code 2'b01 (halfword) gives in_data[15:0] in out_data[15:0]. out_data[63:16] is zero when in_sext is low and is copies of in_data[15] when in_sext is high.
- R5: Size code 2'b10 (word) gives in_data[31:0] in out_data[31:0]. out_data[63:32] is zero when in_sext is low and is copies of in_data[31] when in_sext is high.
- R6: Size code 2'b11 (doubleword) with no flags gives out_data equal to in_data.
- R7: With in_brev high, a halfword gives out_data = {48'b0, in_data[7:0], in_data[15:8]} and a word gives out_data = {32'b0, in_data[7:0], in_data[15:8], in_data[23:16], in_data[31:24]}.
- R8: With in_brev high, a doubleword gives all eight bytes in reverse order: in_data[63:56] lands in out_data[7:0] and in_data[7:0] lands in out_data[63:56].
- R9: With in_brev high, a byte access gives the same result as a plain byte load, with out_data[63:8] zero.
- R10: in_sext high together with the byte size, the doubleword size or in_brev high sets out_err and gives out_data of zero. Every other combination clears out_err.
- R11: Input bits above the access size have no effect on out_data.
- R12: In a cycle with in_valid low, out_data, out_tag and out_err keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load data present this cycle |
| in_data | input | 64 | Raw loaded bytes, right-justified |
| in_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| in_sext | input | 1 | Request algebraic (sign) fill |
| in_brev | input | 1 | Request byte-order reversal within the access |
| in_tag | input | TAG_W | Destination register number |
| out_valid | output | 1 | Formatted result present |
| out_data | output | 64 | Value for the destination register |
| out_tag | output | TAG_W | Destination register number of the result |
| out_err | output | 1 | Unsupported flag combination was requested |

## Verification
The assertions check on every cycle the relations that hold for any data value. These are the one-cycle valid and tag timing, the zero fill above byte and byte-swapped results, the sign-bit copy above algebraic halfwords and words, the unchanged doubleword copy, the zero result on an error, and the held outputs in idle cycles. What the bench's scenarios alone can show is the exact byte placement for each size under reversal, that out-of-size input bits are really ignored, and that each rejected flag combination is reported. The bench compares whole results against its own model over random and directed inputs.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  localparam int LDF_DATA_W = 64;
  localparam int LDF_BYTE_W = 8;
  localparam int LDF_NBYTES = LDF_DATA_W / LDF_BYTE_W;
  localparam int LDF_NSIZE  = $clog2(LDF_NBYTES) + 1;
  localparam int LDF_SIZE_W = $clog2(LDF_NSIZE);

  typedef enum logic [LDF_SIZE_W-1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ldf_size_e;

  // Number of bytes moved by one access of the given size code.
  function automatic int unsigned ldf_bytes(input logic [LDF_SIZE_W-1:0] sz);
    return 32'd1 << sz;
  endfunction

  // Sign fill is only defined for sizes that are neither the smallest
  // nor the full register width, and never together with a byte swap.
  function automatic logic ldf_mode_bad(input logic [LDF_SIZE_W-1:0] sz,
                                        input logic sext,
                                        input logic brev);
    logic mid_size;
    mid_size = (sz != SZ_BYTE) && (sz != SZ_DWORD);
    return sext && (brev || !mid_size);
  endfunction

endpackage

// File: rtl/ldfmt_lane_swap.sv
module ldfmt_lane_swap
  import ldfmt_pkg::*;
(
  input  logic [LDF_DATA_W-1:0] din,
  input  logic [LDF_SIZE_W-1:0] size,
  input  logic                  brev,
  output logic [LDF_DATA_W-1:0] dout
);

  // One candidate per access size: the access bytes, masked to the size,
  // either in their arrival order or reversed.
  logic [LDF_DATA_W-1:0] cand [LDF_NSIZE];

  for (genvar s = 0; s < LDF_NSIZE; s++) begin : g_size
    localparam int NB = 1 << s;
    logic [LDF_DATA_W-1:0] kept;
    logic [LDF_DATA_W-1:0] flip;
    for (genvar b = 0; b < LDF_NBYTES; b++) begin : g_lane
      if (b < NB) begin : g_in
        assign kept[b*LDF_BYTE_W +: LDF_BYTE_W] = din[b*LDF_BYTE_W +: LDF_BYTE_W];
        assign flip[b*LDF_BYTE_W +: LDF_BYTE_W] = din[(NB-1-b)*LDF_BYTE_W +: LDF_BYTE_W];
      end else begin : g_out
        assign kept[b*LDF_BYTE_W +: LDF_BYTE_W] = '0;
        assign flip[b*LDF_BYTE_W +: LDF_BYTE_W] = '0;
      end
    end
    assign cand[s] = brev ? flip : kept;
  end

  assign dout = cand[size];

endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend
  import ldfmt_pkg::*;
(
  input  logic [LDF_DATA_W-1:0] din,
  input  logic [LDF_SIZE_W-1:0] size,
  input  logic                  sext,
  output logic [LDF_DATA_W-1:0] dout,
  output logic                  sign_bit
);

  // din already holds zeros above the access; sign fill replaces them.
  logic [LDF_DATA_W-1:0] ext  [LDF_NSIZE];
  logic                  msb  [LDF_NSIZE];

  for (genvar s = 0; s < LDF_NSIZE; s++) begin : g_size
    localparam int AW = (1 << s) * LDF_BYTE_W;
    assign msb[s] = din[AW-1];
    if (AW < LDF_DATA_W) begin : g_fill
      assign ext[s] = sext ? {{(LDF_DATA_W-AW){din[AW-1]}}, din[AW-1:0]} : din;
    end else begin : g_full
      assign ext[s] = din;
    end
  end

  assign dout     = ext[size];
  assign sign_bit = msb[size];

endmodule

// File: rtl/ldfmt_legal.sv
module ldfmt_legal
  import ldfmt_pkg::*;
(
  input  logic [LDF_SIZE_W-1:0] size,
  input  logic                  sext,
  input  logic                  brev,
  output logic                  bad
);

  assign bad = ldf_mode_bad(size, sext, brev);

endmodule

// File: rtl/ldfmt_unit.sv
module ldfmt_unit
  import ldfmt_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [LDF_DATA_W-1:0] in_data,
  input  logic [LDF_SIZE_W-1:0] in_size,
  input  logic                  in_sext,
  input  logic                  in_brev,
  input  logic [TAG_W-1:0]      in_tag,
  output logic                  out_valid,
  output logic [LDF_DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]      out_tag,
  output logic                  out_err
);

  localparam int HALF_W = 2 * LDF_BYTE_W;
  localparam int WORD_W = 4 * LDF_BYTE_W;

  // Named internal events for the checks below.
  logic [LDF_DATA_W-1:0] lane_data;
  logic [LDF_DATA_W-1:0] fill_data;
  logic                  fill_sign;
  logic                  mode_bad;
  logic [LDF_DATA_W-1:0] result_d;

  ldfmt_lane_swap u_swap (
    .din  (in_data),
    .size (in_size),
    .brev (in_brev),
    .dout (lane_data)
  );

  ldfmt_extend u_ext (
    .din      (lane_data),
    .size     (in_size),
    .sext     (in_sext),
    .dout     (fill_data),
    .sign_bit (fill_sign)
  );

  ldfmt_legal u_legal (
    .size (in_size),
    .sext (in_sext),
    .brev (in_brev),
    .bad  (mode_bad)
  );

  assign result_d = mode_bad ? '0 : fill_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= result_d;
        out_tag  <= in_tag;
        out_err  <= mode_bad;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && out_tag == $past(in_tag));

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size == SZ_BYTE |=> out_data[LDF_DATA_W-1:LDF_BYTE_W] == '0);

  // R4
  half_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sext && !in_brev && in_size == SZ_HALF |=>
      out_data[LDF_DATA_W-1:HALF_W] == {(LDF_DATA_W-HALF_W){out_data[HALF_W-1]}});

  // R5
  word_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sext && !in_brev && in_size == SZ_WORD |=>
      out_data[LDF_DATA_W-1:WORD_W] == {(LDF_DATA_W-WORD_W){out_data[WORD_W-1]}});

  // R5
  sign_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sext && !mode_bad |=> out_data[LDF_DATA_W-1] == $past(fill_sign));

  // R6
  dword_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_size == SZ_DWORD && !in_sext && !in_brev |=> out_data == $past(in_data));

  // R7
  swap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_brev && in_size != SZ_DWORD |=> out_data[LDF_DATA_W-1:WORD_W] == '0);

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_data == '0);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data) && $stable(out_tag) && $stable(out_err));

endmodule

// File: tb/ldfmt_unit_bench.sv
`timescale 1ns/1ps
module ldfmt_unit_bench;

  localparam int TAG_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [63:0]       in_data = '0;
  logic [1:0]        in_size = '0;
  logic              in_sext = 1'b0;
  logic              in_brev = 1'b0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic              out_valid;
  logic [63:0]       out_data;
  logic [TAG_W-1:0]  out_tag;
  logic              out_err;

  int total = 0;
  int bad = 0;
  logic [63:0] last_data;
  logic [TAG_W-1:0] last_tag;
  logic last_err;

  always #2.5 clk = ~clk;

  ldfmt_unit #(.TAG_W(TAG_W)) u_ldfmt_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_size(in_size), .in_sext(in_sext), .in_brev(in_brev), .in_tag(in_tag),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag), .out_err(out_err)
  );

  // Reference: walk the access bit by bit in big-endian order.
  function automatic logic ref_err(input logic [1:0] sz, input logic sx, input logic br);
    return sx && (br || sz == 2'd0 || sz == 2'd3);
  endfunction

  function automatic logic [63:0] ref_fmt(input logic [63:0] d, input logic [1:0] sz,
                                          input logic sx, input logic br);
    int nbits;
    logic [63:0] r;
    nbits = 8 << sz;
    r = '0;
    if (ref_err(sz, sx, br)) return '0;
    for (int k = 0; k < nbits; k++) begin
      // k counts loaded bits from the most significant (big-endian bit k)
      int bytei;
      int biti;
      bytei = k / 8;
      biti  = k % 8;
      if (br) r[bytei*8 + 7 - biti] = d[nbits-1-k];
      else    r[nbits-1-k] = d[nbits-1-k];
    end
    if (sx) for (int k = nbits; k < 64; k++) r[k] = d[nbits-1];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Called at a falling edge; result checked at the next falling edge.
  task automatic do_load(input string req, input logic [63:0] d, input logic [1:0] sz,
                         input logic sx, input logic br, input logic [TAG_W-1:0] tg);
    logic [63:0] e;
    logic ee;
    in_valid = 1'b1; in_data = d; in_size = sz; in_sext = sx; in_brev = br; in_tag = tg;
    e = ref_fmt(d, sz, sx, br);
    ee = ref_err(sz, sx, br);
    @(negedge clk);
    check(req, {63'd0, out_valid}, 64'd1);
    check(req, {{(64-TAG_W){1'b0}}, out_tag}, {{(64-TAG_W){1'b0}}, tg});
    check(req, {63'd0, out_err}, {63'd0, ee});
    check(req, out_data, e);
    last_data = e; last_tag = tg; last_err = ee;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5c_0a77));
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset data", out_data, 64'd0);
    check("R1 reset err", {63'd0, out_err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {out_data[62:0], out_valid}, 64'd0);

    do_load("R3 R11 byte", 64'hDEAD_BEEF_CAFE_12AB, 2'd0, 0, 0, 5'd1);
    do_load("R4 half plain", 64'hFFFF_FFFF_FFFF_8001, 2'd1, 0, 0, 5'd2);
    do_load("R4 half sext neg", 64'h0000_0000_0000_8001, 2'd1, 1, 0, 5'd3);
    do_load("R4 half sext pos", 64'hFFFF_FFFF_FFFF_7FFE, 2'd1, 1, 0, 5'd4);
    do_load("R5 word plain", 64'h1234_5678_8000_0000, 2'd2, 0, 0, 5'd5);
    do_load("R5 word sext neg", 64'h0000_0000_8000_0001, 2'd2, 1, 0, 5'd6);
    do_load("R5 word sext pos", 64'hFFFF_FFFF_7FFF_FFFF, 2'd2, 1, 0, 5'd7);
    do_load("R6 dword", 64'h8123_4567_89AB_CDEF, 2'd3, 0, 0, 5'd8);
    do_load("R7 half brev", 64'hAAAA_AAAA_AAAA_1234, 2'd1, 0, 1, 5'd9);
    do_load("R7 word brev", 64'hFFFF_FFFF_1122_3344, 2'd2, 0, 1, 5'd10);
    do_load("R7 word brev sign", 64'h0000_0000_0000_00F0, 2'd2, 0, 1, 5'd11);
    do_load("R8 dword brev", 64'h0102_0304_0506_0708, 2'd3, 0, 1, 5'd12);
    do_load("R9 byte brev", 64'h5555_5555_5555_55C3, 2'd0, 0, 1, 5'd13);
    do_load("R10 sext byte", 64'h0000_0000_0000_00FF, 2'd0, 1, 0, 5'd14);
    do_load("R10 sext dword", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1, 0, 5'd15);
    do_load("R10 sext brev", 64'h0000_0000_0000_8080, 2'd1, 1, 1, 5'd16);
    do_load("R10 clear after err", 64'h0000_0000_0000_0042, 2'd0, 0, 0, 5'd17);

    // R12: idle with changing inputs
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b0;
      in_data = {$urandom, $urandom};
      in_size = 2'($urandom);
      in_sext = 1'($urandom);
      in_brev = 1'($urandom);
      in_tag = TAG_W'($urandom);
      @(negedge clk);
      check("R12 idle valid", {63'd0, out_valid}, 64'd0);
      check("R12 idle data", out_data, last_data);
      check("R12 idle tag/err", {58'd0, out_tag, out_err}, {58'd0, last_tag, last_err});
    end

    // R11: same access bytes with different upper garbage
    for (int i = 0; i < 40; i++) begin
      logic [63:0] d;
      logic [1:0] sz;
      d = {$urandom, $urandom};
      sz = 2'($urandom % 3);
      do_load("R11 upper ignored", d, sz, 1'($urandom), 1'($urandom), TAG_W'(i));
    end

    // Random mix, back-to-back (R2 R3 R4 R5 R6 R7 R8 R10)
    for (int i = 0; i < 400; i++) begin
      do_load("R2 random", {$urandom, $urandom}, 2'($urandom), 1'($urandom),
              1'($urandom), TAG_W'($urandom));
      if (($urandom % 5) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 gap", {63'd0, out_valid}, 64'd0);
        check("R12 gap data", out_data, last_data);
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule